// File: doc/BRIEF.md
# Shared-Line Serial Converter Host Controller

This block runs the host side of a serial link to a 12-bit sampling converter that has an 8-way input selector in front of it. The link is one serial clock, two active-low selects (one for the input selector, one for the converter) and a single data wire that both ends drive in turn. The controller makes the serial clock from the system clock with a fixed divider. It writes the channel address onto the shared wire, releases the wire, and shifts in the conversion result that the converter sends back.

A client raises `req_valid` with a channel number while `busy` is low. If that channel is not the one the selector already holds (or none is held yet), an address frame runs first. The address frame is followed by one idle serial period and then a conversion frame. If the channel is unchanged, only the conversion frame runs. At the end of a conversion frame the 12-bit result appears on `res_data` with a one-cycle `res_valid` pulse. Requests made while `busy` is high are dropped.

The host changes its outgoing bit on falling serial clock edges and samples incoming bits on rising edges. The wire is driven by the host at all times except while the converter select is low. The `dline_oe` output shows when the host is driving.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset both selects are high, `sclk` is low, `busy` and `res_valid` are low, and `dline_oe` is high.
- R2: The first request after reset, and any request whose channel differs from the last one addressed, starts an address frame. In that frame `mux_cs_n` stays low for 4 serial periods. The host drives the bits 1, c[2], c[1], c[0] in that order, each valid at a rising `sclk` edge. The address frame is followed by a conversion frame.
- R3: A request for the channel already addressed runs a conversion frame only, with `mux_cs_n` held high.
- R4: While `adc_cs_n` is low, `dline_oe` is low. While `mux_cs_n` is low, `dline_oe` is high. The host never drives the wire while the converter drives it.
- R5: A conversion frame lasts 14 serial periods. The host samples the wire on each rising edge, and the last 12 samples form the result, first sample the most significant bit (bit 11). The first of the 14 periods is a settle period and the second carries the converter's null bit.
- R6: `res_valid` is high for exactly one system cycle, in the cycle in which `adc_cs_n` has just returned high. Counted from the accepting clock edge, it rises 28*SCLK_HALF cycles later for an unchanged channel and 38*SCLK_HALF cycles later when an address frame runs first.
- R7: The two selects are never low together, and before either falls both have been high for at least one serial period (2*SCLK_HALF system cycles).
- R8: `busy` goes high on the edge that accepts a request and stays high through every frame. A request made while `busy` is high starts no frame and does not change the addressed channel.
- R9: If a request for an unchanged channel is held asserted, results come every 30*SCLK_HALF+1 system cycles. At 100 MHz with SCLK_HALF=4 this is far above 20 k samples per second.
- R10: The serial clock has a period of 2*SCLK_HALF system cycles inside a frame and is low whenever both selects are high.
- R11: All eight channels, 0 to 7, can be addressed, and the channel the selector latches equals the requested one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request, accepted when `busy` is low |
| req_chan | input | 3 | Channel number of the request |
| busy | output | 1 | A frame sequence is in progress |
| res_valid | output | 1 | One-cycle strobe for `res_data` |
| res_data | output | 12 | Conversion result |
| sclk | output | 1 | Serial clock to the converter |
| mux_cs_n | output | 1 | Active-low select of the input selector |
| adc_cs_n | output | 1 | Active-low select of the converter |
| dline_o | output | 1 | Value the host puts on the shared wire |
| dline_oe | output | 1 | High while the host drives the shared wire |
| dline_i | input | 1 | Value read back from the shared wire |

## Verification
The main path is run with random channels biased toward repeats, so address-plus-conversion sequences and conversion-only sequences are mixed. Comparing the measured latency and the address-frame count against the expected path shows whether the controller chose the right frame sequence. Result words of all zeros, all ones and alternating bits come back from a modelled converter. These catch an off-by-one in the sampling window, a bit-order reversal or a stuck bit. Directed runs over all eight channels, a request made while busy, and a held request for an unchanged channel separate address decoding, request dropping and back-to-back throughput.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MUX  = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_ADC  = 2'd3
    } seq_state_e;

    // Registered link pin controls, all active-high inside the block
    typedef struct packed {
        logic mux_sel;
        logic adc_sel;
        logic drive;
        logic run;
    } link_ctl_t;

    // Marker bit that precedes the channel number in an address word
    localparam int unsigned EN_BITS  = 1;
    // Settle period plus null bit ahead of the result bits
    localparam int unsigned PRE_BITS = 2;

    function automatic int unsigned mux_periods(int unsigned chan_w);
        return chan_w + EN_BITS;
    endfunction

    function automatic int unsigned adc_periods(int unsigned res_w);
        return res_w + PRE_BITS;
    endfunction

    // Width of a counter that runs 0 .. n-1
    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_host_sclk_gen.sv
module adc_host_sclk_gen #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_tick,
    output logic fall_tick
);
    logic edge_now;

    generate
        if (HALF == 1) begin : g_every_cycle
            assign edge_now = run;
        end else begin : g_divided
            localparam int unsigned CW = $clog2(HALF);
            localparam logic [CW-1:0] LAST = CW'(HALF - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign edge_now = run && (cnt == LAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk <= 1'b0;
        end else if (edge_now) begin
            sclk <= ~sclk;
        end else if (!run) begin
            sclk <= 1'b0;
        end
    end

    assign rise_tick = edge_now & ~sclk;
    assign fall_tick = edge_now &  sclk;

endmodule

// File: rtl/adc_host_tx.sv
module adc_host_tx #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         shift,
    output logic         bit_out
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= word;
        end else if (shift) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign bit_out = sh[W-1];

endmodule

// File: rtl/adc_host_rx.sv
module adc_host_rx #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift) begin
            word <= {word[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_host_pkg::*;
#(
    parameter int unsigned CHAN_W    = 3,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic [RES_W-1:0]  rx_word,
    output logic              busy,
    output link_ctl_t         ctl,
    output logic              tx_load,
    output logic [CHAN_W:0]   tx_word,
    output logic              tx_shift,
    output logic              rx_shift,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data
);
    localparam int unsigned MUX_N = mux_periods(CHAN_W);
    localparam int unsigned ADC_N = adc_periods(RES_W);
    localparam int unsigned FC_W  = cnt_width(max_u(MUX_N, ADC_N));
    localparam int unsigned GAP_N = 2 * SCLK_HALF;
    localparam int unsigned GAP_W = cnt_width(GAP_N);

    localparam logic [FC_W-1:0]  MUX_LAST = FC_W'(MUX_N - 1);
    localparam logic [FC_W-1:0]  ADC_LAST = FC_W'(ADC_N - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_N - 1);

    localparam link_ctl_t CTL_REST = '{mux_sel: 1'b0, adc_sel: 1'b0, drive: 1'b1, run: 1'b0};

    seq_state_e        state;
    logic [FC_W-1:0]   fcnt;
    logic [GAP_W-1:0]  gcnt;
    logic              have_chan;
    logic [CHAN_W-1:0] cur_chan;
    logic              adc_next;
    logic              need_addr;

    assign need_addr = !have_chan || (req_chan != cur_chan);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            ctl       <= CTL_REST;
            fcnt      <= '0;
            gcnt      <= '0;
            have_chan <= 1'b0;
            cur_chan  <= '0;
            adc_next  <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        fcnt <= '0;
                        if (need_addr) begin
                            state       <= SEQ_MUX;
                            ctl.mux_sel <= 1'b1;
                            ctl.run     <= 1'b1;
                            cur_chan    <= req_chan;
                            have_chan   <= 1'b1;
                        end else begin
                            state       <= SEQ_ADC;
                            ctl.adc_sel <= 1'b1;
                            ctl.drive   <= 1'b0;
                            ctl.run     <= 1'b1;
                        end
                    end
                end
                SEQ_MUX: begin
                    if (fall_tick) begin
                        if (fcnt == MUX_LAST) begin
                            fcnt        <= '0;
                            ctl.mux_sel <= 1'b0;
                            ctl.run     <= 1'b0;
                            adc_next    <= 1'b1;
                            state       <= SEQ_GAP;
                        end else begin
                            fcnt <= fcnt + 1'b1;
                        end
                    end
                end
                SEQ_GAP: begin
                    if (gcnt == GAP_LAST) begin
                        gcnt <= '0;
                        if (adc_next) begin
                            state       <= SEQ_ADC;
                            ctl.adc_sel <= 1'b1;
                            ctl.drive   <= 1'b0;
                            ctl.run     <= 1'b1;
                        end else begin
                            state <= SEQ_IDLE;
                        end
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                SEQ_ADC: begin
                    if (fall_tick) begin
                        if (fcnt == ADC_LAST) begin
                            fcnt        <= '0;
                            ctl.adc_sel <= 1'b0;
                            ctl.drive   <= 1'b1;
                            ctl.run     <= 1'b0;
                            adc_next    <= 1'b0;
                            res_valid   <= 1'b1;
                            res_data    <= rx_word;
                            state       <= SEQ_GAP;
                        end else begin
                            fcnt <= fcnt + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state != SEQ_IDLE);
    assign tx_load  = (state == SEQ_IDLE) && req_valid && need_addr;
    assign tx_word  = {1'b1, req_chan};
    assign tx_shift = (state == SEQ_MUX) && fall_tick;
    assign rx_shift = (state == SEQ_ADC) && rise_tick;

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int unsigned CHAN_W    = 3,
    parameter int unsigned RES_W     = 12,
    parameter int unsigned SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CHAN_W-1:0] req_chan,
    output logic              busy,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    output logic              sclk,
    output logic              mux_cs_n,
    output logic              adc_cs_n,
    output logic              dline_o,
    output logic              dline_oe,
    input  logic              dline_i
);
    localparam int unsigned ADDR_W = CHAN_W + EN_BITS;

    link_ctl_t         ctl;
    logic              rise_tick;
    logic              fall_tick;
    logic              tx_load;
    logic [ADDR_W-1:0] tx_word;
    logic              tx_shift;
    logic              rx_shift;
    logic [RES_W-1:0]  rx_word;

    adc_host_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl.run),
        .sclk      (sclk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    adc_host_seq #(
        .CHAN_W    (CHAN_W),
        .RES_W     (RES_W),
        .SCLK_HALF (SCLK_HALF)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .rx_word   (rx_word),
        .busy      (busy),
        .ctl       (ctl),
        .tx_load   (tx_load),
        .tx_word   (tx_word),
        .tx_shift  (tx_shift),
        .rx_shift  (rx_shift),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    adc_host_tx #(.W(ADDR_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .word    (tx_word),
        .shift   (tx_shift),
        .bit_out (dline_o)
    );

    adc_host_rx #(.W(RES_W)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .shift  (rx_shift),
        .bit_in (dline_i),
        .word   (rx_word)
    );

    assign mux_cs_n = ~ctl.mux_sel;
    assign adc_cs_n = ~ctl.adc_sel;
    assign dline_oe = ctl.drive;

endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk #(
    parameter int unsigned SCLK_HALF = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic res_valid,
    input logic sclk,
    input logic mux_cs_n,
    input logic adc_cs_n,
    input logic dline_o,
    input logic dline_oe
);
    localparam logic [15:0] HI_CAP  = 16'hFFFF;
    localparam logic [15:0] HI_NEED = 16'(2 * SCLK_HALF - 1);

    // Cycles both selects have been high, saturating
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= HI_CAP;
        end else if (!mux_cs_n || !adc_cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_CAP) begin
            hi_cnt <= hi_cnt + 16'd1;
        end
    end

    assert_release_in_adc_R4: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> !dline_oe);

    assert_drive_in_mux_R4: assert property (@(posedge clk) disable iff (rst)
        !mux_cs_n |-> dline_oe);

    assert_marker_first_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mux_cs_n) |-> (dline_oe && dline_o));

    assert_sel_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(!mux_cs_n && !adc_cs_n));

    assert_sel_gap_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(mux_cs_n) || $fell(adc_cs_n)) |-> ($past(hi_cnt) >= HI_NEED));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_valid_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $rose(adc_cs_n));

    assert_busy_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
        (!mux_cs_n || !adc_cs_n) |-> busy);

    assert_sclk_rest_R10: assert property (@(posedge clk) disable iff (rst)
        (mux_cs_n && adc_cs_n) |-> !sclk);

endmodule

bind adc_host_ctrl adc_host_chk #(.SCLK_HALF(SCLK_HALF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .res_valid (res_valid),
    .sclk      (sclk),
    .mux_cs_n  (mux_cs_n),
    .adc_cs_n  (adc_cs_n),
    .dline_o   (dline_o),
    .dline_oe  (dline_oe)
);

// File: tb/tb_adc_host_ctrl.sv
`timescale 1ns/1ps
module tb_adc_host_ctrl;
    localparam int H  = 4;
    localparam int CW = 3;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [CW-1:0] req_chan = '0;
    logic          busy, res_valid, sclk, mux_cs_n, adc_cs_n, dline_o, dline_oe;
    logic [RW-1:0] res_data;
    logic          shared_line;

    always #5 clk = ~clk;

    adc_host_ctrl #(.CHAN_W(CW), .RES_W(RW), .SCLK_HALF(H)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .sclk(sclk), .mux_cs_n(mux_cs_n), .adc_cs_n(adc_cs_n),
        .dline_o(dline_o), .dline_oe(dline_oe), .dline_i(shared_line)
    );

    // ---------------- converter model ----------------
    logic          dev_drive = 1'b0;
    logic          dev_bit   = 1'b0;
    logic [12:0]   dev_sh    = '0;
    logic [RW-1:0] dev_next  = '0;
    logic [RW-1:0] dev_word  = '0;
    logic [3:0]    mux_sh    = '0;
    int            mux_bits  = 0;
    int            mux_frames = 0;
    int            mux_bad   = 0;
    int            adc_frames = 0;
    logic [CW-1:0] dev_chan  = '0;

    assign shared_line = dline_oe ? dline_o : (dev_drive ? dev_bit : 1'b1);

    always @(negedge adc_cs_n) begin
        dev_word   = dev_next;
        dev_sh     = {1'b0, dev_next};
        dev_drive  = 1'b0;
        adc_frames = adc_frames + 1;
    end

    always @(posedge adc_cs_n) dev_drive = 1'b0;

    always @(negedge sclk) begin
        if (!adc_cs_n) begin
            dev_drive = 1'b1;
            dev_bit   = dev_sh[12];
            dev_sh    = {dev_sh[11:0], 1'b0};
        end
    end

    always @(negedge mux_cs_n) mux_bits = 0;

    always @(posedge sclk) begin
        if (!mux_cs_n) begin
            mux_sh   = {mux_sh[2:0], shared_line};
            mux_bits = mux_bits + 1;
        end
    end

    always @(posedge mux_cs_n) begin
        if (!rst) begin
            mux_frames = mux_frames + 1;
            if (mux_bits == 4 && mux_sh[3]) dev_chan = mux_sh[2:0];
            else mux_bad = mux_bad + 1;
        end
    end

    // ---------------- bookkeeping monitors ----------------
    int  n_chk = 0, n_bad = 0;
    int  n_res = 0, n_overlap = 0, n_both = 0, n_sclk_rest = 0;
    int  hi_run = 1000000, min_gap = 1000000;
    logic prev_both_hi = 1'b1;
    time rise_last = 0, rise_prev = 0;
    bit  done = 0;

    always @(posedge clk) if (!rst && res_valid) n_res = n_res + 1;

    always @(posedge sclk) begin
        rise_prev = rise_last;
        rise_last = $time;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (dline_oe && dev_drive) n_overlap = n_overlap + 1;
            if (!mux_cs_n && !adc_cs_n) n_both = n_both + 1;
            if (mux_cs_n && adc_cs_n && sclk) n_sclk_rest = n_sclk_rest + 1;
            if (mux_cs_n && adc_cs_n) begin
                hi_run = hi_run + 1;
            end else begin
                if (prev_both_hi && hi_run < min_gap) min_gap = hi_run;
                hi_run = 0;
            end
            prev_both_hi = mux_cs_n && adc_cs_n;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Expected latency from the accepting edge, counted in negedges
    function automatic int exp_latency(input bit with_addr);
        return (with_addr ? 38 * H : 28 * H) + 1;
    endfunction

    bit            have = 0;
    logic [CW-1:0] last_ch = '0;

    task automatic wait_idle;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic do_conv(input logic [CW-1:0] ch, input logic [RW-1:0] word);
        bit need;
        int mf0, cnt;
        wait_idle();
        need      = !have || (ch != last_ch);
        mf0       = mux_frames;
        dev_next  = word;
        req_chan  = ch;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 1;
        check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        while (!res_valid && cnt < 4000) begin
            @(negedge clk);
            cnt = cnt + 1;
        end
        check(cnt == exp_latency(need), "R6 result latency", cnt, exp_latency(need));
        check(res_data == word, "R5 result word", int'(res_data), int'(word));
        if (need) check(mux_frames - mf0 == 1, "R2 address frame count", mux_frames - mf0, 1);
        else      check(mux_frames - mf0 == 0, "R3 no address frame", mux_frames - mf0, 0);
        check(dev_chan == ch, "R11 latched channel", int'(dev_chan), int'(ch));
        check(rise_last - rise_prev == 2 * H * 10, "R10 sclk period",
              int'(rise_last - rise_prev), 2 * H * 10);
        @(negedge clk);
        check(res_valid == 1'b0, "R6 strobe width", int'(res_valid), 0);
        have    = 1;
        last_ch = ch;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int seed_sink;
        int res0, mf0, af0, t1, t2, cnt;
        seed_sink = $urandom(32'd20240);
        repeat (5) @(negedge clk);
        // R1 reset state
        check(mux_cs_n && adc_cs_n, "R1 selects high", int'({mux_cs_n, adc_cs_n}), 3);
        check(!sclk, "R1 sclk low", int'(sclk), 0);
        check(!busy && !res_valid, "R1 busy/valid low", int'({busy, res_valid}), 0);
        check(dline_oe, "R1 host drives line", int'(dline_oe), 1);
        rst = 1'b0;

        // Directed corner words and every channel (R11, R5)
        do_conv(3'd0, 12'h000);
        do_conv(3'd0, 12'hFFF);
        do_conv(3'd7, 12'hA55);
        do_conv(3'd7, 12'h5AA);
        for (int c = 0; c < 8; c++) do_conv(c[CW-1:0], 12'(12'h801 + c * 12'h111));

        // Request while busy is dropped (R8)
        wait_idle();
        res0 = n_res;
        dev_next  = 12'h3C3;
        req_chan  = 3'd2;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        req_chan  = 3'd5;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        mf0 = mux_frames;
        af0 = adc_frames;
        repeat (50 * H) @(negedge clk);
        check(n_res - res0 == 1, "R8 one result only", n_res - res0, 1);
        check(mux_frames == mf0 && adc_frames == af0, "R8 no frame from dropped request",
              (mux_frames - mf0) + (adc_frames - af0), 0);
        check(dev_chan == 3'd2, "R8 channel unchanged", int'(dev_chan), 2);
        check(res_data == 12'h3C3, "R5 word after drop", int'(res_data), 'h3C3);
        last_ch = 3'd2;

        // Held request on an unchanged channel (R9)
        wait_idle();
        dev_next  = 12'h0F0;
        req_chan  = 3'd2;
        req_valid = 1'b1;
        cnt = 0; t1 = -1; t2 = -1;
        while (t2 < 0 && cnt < 4000) begin
            @(negedge clk);
            cnt = cnt + 1;
            if (res_valid) begin
                if (t1 < 0) t1 = cnt;
                else t2 = cnt;
            end
        end
        req_valid = 1'b0;
        check(t2 - t1 == 30 * H + 1, "R9 back-to-back period", t2 - t1, 30 * H + 1);

        // Random mix, biased toward repeats
        for (int i = 0; i < 40; i++) begin
            logic [CW-1:0] ch;
            ch = ($urandom % 3 == 0) ? last_ch : CW'($urandom % 8);
            do_conv(ch, RW'($urandom));
        end

        wait_idle();
        repeat (4 * H) @(negedge clk);
        check(n_overlap == 0, "R4 no drive overlap", n_overlap, 0);
        check(mux_bad == 0, "R2 address word shape", mux_bad, 0);
        check(n_both == 0, "R7 selects exclusive", n_both, 0);
        check(min_gap >= 2 * H, "R7 select high gap", min_gap, 2 * H);
        check(n_sclk_rest == 0, "R10 sclk low at rest", n_sclk_rest, 0);
        finish_run();
    end

endmodule